// File: doc/BRIEF.md
# Relay Shift-Out Sequencer

This block sits on the host side of a serial-in, latched relay driver. A requester presents an 8-bit relay pattern and pulses a start input. The block then generates the shift clock, serial data, latch strobe and active-low gate enable that the driver needs. When the new pattern has reached the driver outputs, it returns a one-cycle completion pulse. A busy flag is high for the whole transfer, so the requester knows when it may issue the next pattern.

The transfer is built from timed phases. Every phase lasts `HALF_CYCLES` system clocks. First the enable falls and the strobe is held low for a setup phase. Each bit then takes a clock-low phase, during which the data line is updated, followed by a clock-high phase, during which the driver samples the bit. After the last bit, the strobe is raised for one phase and then held low for one phase. This copies the shifted pattern to the driver outputs. The most significant bit drives relay 1 and is shifted first. It therefore ends up in the stage furthest from the serial input.

Top module: `relay_shift_seq`

## Requirements
- R1: After reset, sclk_o, sdata_o, strobe_o, busy_o and done_o are 0 and gate_en_n_o is 1.
- R2: A start_i sampled high while idle makes busy_o 1 and gate_en_n_o 0 from the next cycle. Both hold for the whole transfer, and gate_en_n_o returns to 1 once the transfer is over.
- R3: Bits are sent most significant first: bit 7 (relay 1) goes first and bit 0 (relay 8) goes last. A driver that shifts on each rising edge of sclk_o and latches on the falling edge of strobe_o ends up holding the requested pattern.
- R4: sdata_o changes only while sclk_o is low. It is stable for every cycle in which sclk_o is high.
- R5: sclk_o produces exactly WIDTH high pulses per transfer. Each pulse lasts HALF_CYCLES cycles.
- R6: strobe_o stays low during the setup phase and every bit phase. After the last clock pulse it is high for exactly HALF_CYCLES cycles while sclk_o is low, and then low for HALF_CYCLES cycles.
- R7: done_o is a single-cycle pulse. It appears in the same cycle that busy_o falls, which is (3+2·WIDTH)·HALF_CYCLES+1 cycles after start_i is driven, measured at the sampling point described under Verification.
- R8: A start_i pulse that arrives while busy_o is 1 is ignored. The pattern in flight, the transfer length and the single done_o pulse are all unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send pattern_i |
| pattern_i | input | WIDTH | Relay pattern, bit 7 = relay 1 |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Shift clock to driver |
| sdata_o | output | 1 | Serial data to driver |
| strobe_o | output | 1 | Latch strobe to driver |
| gate_en_n_o | output | 1 | Active-low enable for the signal gates |

## Verification
The bench drives start_i at a falling edge and counts falling edges from that point. busy_o is therefore due at count 1, and done_o is due at count 19·HALF_CYCLES+1 (77 with the default values). Both are compared at exactly those counts. A driver model samples the outputs at every falling edge. It measures the length of each sclk_o and strobe_o high run and checks that data is stable while the clock is high. It latches the pattern on the strobe's falling edge, so the relay image is compared only after the latch has happened.

// File: rtl/relay_shift_seq.sv
module relay_shift_seq #(
  parameter int WIDTH       = 8,
  parameter int HALF_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] pattern_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             strobe_o,
  output logic             gate_en_n_o
);
  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_STBH, S_STBL} state_t;

  state_t           state;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bit_cnt;
  logic [WIDTH-1:0] shreg;
  logic             phase_end;

  assign phase_end   = (cnt == CW'(HALF_CYCLES - 1));
  assign busy_o      = (state != S_IDLE);
  assign gate_en_n_o = (state == S_IDLE);
  assign sclk_o      = (state == S_HIGH);
  assign strobe_o    = (state == S_STBH);
  assign sdata_o     = shreg[WIDTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (state == S_IDLE) begin
        cnt <= '0;
        if (start_i) begin
          state   <= S_SETUP;
          shreg   <= pattern_i;
          bit_cnt <= '0;
        end
      end else if (!phase_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        unique case (state)
          S_SETUP: state <= S_LOW;
          S_LOW:   state <= S_HIGH;
          S_HIGH: begin
            shreg   <= {shreg[WIDTH-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
            state   <= (bit_cnt == BW'(WIDTH - 1)) ? S_STBH : S_LOW;
          end
          S_STBH:  state <= S_STBL;
          S_STBL: begin
            state  <= S_IDLE;
            done_o <= 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o)); // R4
  AST_GATE_OPEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o || strobe_o) |-> !gate_en_n_o); // R2
  AST_STROBE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> !sclk_o); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !strobe_o && !sclk_o)); // R7
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i)); // R8
endmodule

// File: tb/relay_shift_seq_bench.sv
module relay_shift_seq_bench;
  localparam int W = 8;
  localparam int H = 4;
  localparam int TOTAL = (3 + 2 * W) * H + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [W-1:0] pattern_i = '0;
  logic busy_o, done_o, sclk_o, sdata_o, strobe_o, gate_en_n_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  relay_shift_seq #(.WIDTH(W), .HALF_CYCLES(H)) u_relay_shift_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pattern_i(pattern_i),
    .busy_o(busy_o), .done_o(done_o), .sclk_o(sclk_o), .sdata_o(sdata_o),
    .strobe_o(strobe_o), .gate_en_n_o(gate_en_n_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    check(sclk_o == 0 && sdata_o == 0 && strobe_o == 0, "R1 driver lines",
          {sclk_o, sdata_o, strobe_o}, 0);
    check(busy_o == 0 && done_o == 0, "R1 handshake", {busy_o, done_o}, 0);
    check(gate_en_n_o == 1, "R1 gate enable", gate_en_n_o, 1);
  endtask

  // Drives one transfer; optionally injects a second start mid-flight.
  task automatic run_xfer(input logic [W-1:0] pat, input bit inject, input logic [W-1:0] pat2);
    logic [W-1:0] drv_sh = '0;
    logic [W-1:0] latched = '0;
    int clk_pulses = 0, stb_pulses = 0, run = 0, srun = 0;
    int done_at = -1, done_cnt = 0, busy_fall = -1;
    bit bad_hold = 0, bad_run = 0, bad_srun = 0, bad_gate = 0, bad_stb = 0, bad_busy1 = 0;
    logic p_sclk = 0, p_stb = 0, p_data = 0;
    @(negedge clk);
    pattern_i = pat;
    start_i = 1'b1;
    for (int n = 1; n <= TOTAL + 6; n++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (inject && n == 20) begin
        start_i = 1'b1;
        pattern_i = pat2;
      end
      if (n == 1 && (!busy_o || gate_en_n_o)) bad_busy1 = 1;
      if (n >= 1 && n < TOTAL && (!busy_o || gate_en_n_o)) bad_gate = 1;
      if (sclk_o && p_sclk && sdata_o != p_data) bad_hold = 1;
      if (sclk_o && !p_sclk) begin
        drv_sh = {drv_sh[W-2:0], sdata_o};
        clk_pulses++;
      end
      if (strobe_o && clk_pulses != W) bad_stb = 1;
      if (sclk_o) run++;
      else if (p_sclk) begin
        if (run != H) bad_run = 1;
        run = 0;
      end
      if (strobe_o) srun++;
      if (strobe_o && !p_stb) stb_pulses++;
      if (!strobe_o && p_stb) begin
        latched = drv_sh;
        if (srun != H) bad_srun = 1;
        srun = 0;
      end
      if (done_o) begin
        done_cnt++;
        if (done_at < 0) done_at = n;
      end
      if (!busy_o && busy_fall < 0 && n > 1) busy_fall = n;
      p_sclk = sclk_o; p_stb = strobe_o; p_data = sdata_o;
    end
    check(!bad_busy1, "R2 busy/gate next cycle", bad_busy1, 0);
    check(!bad_gate, "R2 gate held low while busy", bad_gate, 0);
    check(gate_en_n_o == 1 && busy_o == 0, "R2 gate released", gate_en_n_o, 1);
    check(latched == pat, "R3 latched relay image", latched, pat);
    check(!bad_hold, "R4 data stable with clock high", bad_hold, 0);
    check(clk_pulses == W, "R5 clock pulse count", clk_pulses, W);
    check(!bad_run, "R5 clock high width", bad_run, 0);
    check(stb_pulses == 1 && !bad_stb, "R6 single strobe after last bit", stb_pulses, 1);
    check(!bad_srun, "R6 strobe width", bad_srun, 0);
    check(done_at == TOTAL, "R7 done timing", done_at, TOTAL);
    check(busy_fall == TOTAL, "R7 busy falls with done", busy_fall, TOTAL);
    check(done_cnt == 1, inject ? "R8 one done despite extra start" : "R7 done pulse count",
          done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_xfer(8'h80, 0, '0);
    run_xfer(8'h01, 0, '0);
    run_xfer(8'hA5, 0, '0);
    run_xfer(8'hFF, 0, '0);
    run_xfer(8'h00, 0, '0);
    run_xfer(8'h3C, 1, 8'hC3); // R8
    check(busy_o == 0, "R8 no second transfer", busy_o, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule